// File: doc/BRIEF.md
# Receive Acquisition and Frame Timing Controller

This block sits at the front of a binary tone-keyed receiver. It takes a stream of signed audio-rate samples, each marked by a valid strobe. From them it decides whether a signal is present, locks onto the synchronisation impulse sent at the head of every frame, and then counts samples to mark where each data bit starts. A downstream correlator and decision stage uses the bit-start strobe and the bit index to integrate one bit period of samples at a time. Tone correlation and bit decisions are not part of this block.

The block has four control states: initialise, idle, acquire and receive. Presence is judged from a moving sum of squared samples compared against a programmable power threshold. The impulse is found by comparing the sample magnitude against a second threshold. With the defaults, a frame has one impulse slot followed by 17 data bits of 80 samples each, which gives 600 bits per second at a 48 kHz sample rate. Every length is a parameter.

Top module: `fsk_rx_sync_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `clr` is sampled high, `state` is 0 (init), `frame_start` and `bit_strobe` are low, `bit_idx` is 0, and the power window is empty.
- R2: The state encoding is 0 init, 1 idle, 2 acquire, 3 receive. Init lasts one cycle and then moves to idle. The power window is emptied during init.
- R3: The power estimate is the sum of the squares of the last PWR_WIN accepted samples. Idle moves to acquire on the clock after the estimate is strictly greater than `pwr_thr`. It stays idle when the estimate is equal to or below the threshold.
- R4: In acquire, an accepted sample whose two's-complement magnitude is strictly greater than `imp_thr` moves the block to receive and raises `frame_start` for one cycle. That sample is offset 0 of the frame.
- R5: Offsets count the accepted samples after the impulse. At offset SPB*(k+1), for k = 0 to BITS-1, `bit_strobe` pulses for one cycle and `bit_idx` becomes k. `bit_idx` holds between strobes and returns to 0 on each `frame_start`.
- R6: In receive, a sample above the impulse threshold at offsets 1 to SPB*(BITS+1)-1 (the guard slot and all data windows) is ignored. Bit timing is not disturbed.
- R7: In receive, an impulse at an offset from SPB*(BITS+1) up to SPB*(BITS+2) inclusive restarts the frame. It raises `frame_start` and sets the new offset to 0.
- R8: If the offset reaches SPB*(BITS+2) with no impulse, the block returns to idle. The offset counts from the impulse in receive, and from entry into the state in acquire.
- R9: In acquire or receive, an estimate equal to or below `pwr_thr` sends the block to idle on the next clock. This check takes priority over impulses and timeouts.
- R10: A cycle with `in_valid` low changes neither the power estimate nor the offset, and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear to the init state |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | SAMPLE_W | Received sample, two's complement |
| pwr_thr | input | 2*SAMPLE_W+clog2(PWR_WIN) | Signal-presence threshold on the power estimate |
| imp_thr | input | SAMPLE_W | Impulse magnitude threshold, unsigned |
| state | output | 2 | Control state (0 init, 1 idle, 2 acquire, 3 receive) |
| frame_start | output | 1 | One-cycle pulse when an impulse is accepted |
| bit_strobe | output | 1 | One-cycle pulse at the first sample of each data bit window |
| bit_idx | output | clog2(BITS) | Index of the bit window last started |

## Verification
The hardest condition to reach is an impulse that lands exactly on a window boundary: the last guard offset, the first post-frame offset, or the timeout offset itself. Each of these must happen while the power estimate stays above threshold. The bench uses a reduced configuration (4-sample bits, 3 bits, 4-sample power window) and keeps a steady alternating tone running. It then sweeps the position of an injected impulse across every offset from 1 to beyond the timeout. After each position it lets the signal collapse back to idle, so that every boundary is driven from a fresh acquisition.

// File: rtl/fsk_sync_pkg.sv
package fsk_sync_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_ACQ  = 2'd2,
    ST_RECV = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_rst_sync.sv
// Asynchronous assertion, synchronous two-stage release.
module rx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/rx_power_est.sv
// Moving sum of squared samples over the last WIN accepted samples.
module rx_power_est #(
  parameter int W   = 16,
  parameter int WIN = 80,
  parameter int PW  = 2*W + $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          vld,
  input  logic [W-1:0]  smp,
  output logic [PW-1:0] pwr
);
  localparam int SQ_W  = 2*W;
  localparam int PAD_W = PW - SQ_W;

  logic [W-1:0]    line_q [WIN];
  logic [SQ_W-1:0] sq_new, sq_old;
  logic [PW-1:0]   pwr_d;
  logic            pwr_en;

  function automatic logic [SQ_W-1:0] square(input logic [W-1:0] v);
    logic signed [SQ_W-1:0] ext;
    ext = {{W{v[W-1]}}, v};
    return $unsigned(ext * ext);
  endfunction

  for (genvar g = 0; g < WIN; g++) begin : g_tap
    logic [W-1:0] tap_d;
    if (g == 0) begin : g_head
      assign tap_d = smp;
    end else begin : g_body
      assign tap_d = line_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      line_q[g] <= '0;
      else if (wipe)   line_q[g] <= '0;
      else if (vld)    line_q[g] <= tap_d;
    end
  end

  always_comb begin
    sq_new = square(smp);
    sq_old = square(line_q[WIN-1]);
    pwr_en = wipe | vld;
    if (wipe) pwr_d = '0;
    else      pwr_d = pwr + {{PAD_W{1'b0}}, sq_new} - {{PAD_W{1'b0}}, sq_old};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr <= '0;
    else if (pwr_en) pwr <= pwr_d;
  end
endmodule

// File: rtl/rx_impulse_det.sv
// Magnitude threshold test on one two's-complement sample.
module rx_impulse_det #(
  parameter int W = 16
) (
  input  logic [W-1:0] smp,
  input  logic [W-1:0] thr,
  output logic         hit
);
  logic [W-1:0] mag;

  always_comb begin
    mag = smp[W-1] ? (~smp + W'(1)) : smp;
    hit = mag > thr;
  end
endmodule

// File: rtl/rx_sync_fsm.sv
// Four-state controller with offset counting split into phase and slot.
module rx_sync_fsm
  import fsk_sync_pkg::*;
#(
  parameter int SPB   = 80,
  parameter int BITS  = 17,
  parameter int IDX_W = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vld,
  input  logic             hit,
  input  logic             pwr_ok,
  output rx_state_e        st,
  output logic             fs,
  output logic             bs,
  output logic [IDX_W-1:0] bidx
);
  localparam int PH_W   = (SPB > 1) ? $clog2(SPB) : 1;
  localparam int SLOT_W = $clog2(BITS + 3);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(SPB - 1);
  localparam logic [SLOT_W-1:0] SLOT_DATA = SLOT_W'(BITS);
  localparam logic [SLOT_W-1:0] SLOT_WAIT = SLOT_W'(BITS + 1);
  localparam logic [SLOT_W-1:0] SLOT_TO   = SLOT_W'(BITS + 2);

  rx_state_e         st_d;
  logic [PH_W-1:0]   ph_q, ph_d, ph_a;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_a;
  logic              fs_d, bs_d;
  logic [IDX_W-1:0]  bidx_d;
  logic              to_a, win_a, late_a;

  // Offset after accepting one more sample
  always_comb begin
    if (ph_q == PH_LAST) begin
      ph_a   = '0;
      slot_a = slot_q + SLOT_W'(1);
    end else begin
      ph_a   = ph_q + PH_W'(1);
      slot_a = slot_q;
    end
    to_a   = (slot_a == SLOT_TO);
    late_a = (slot_a >= SLOT_WAIT);
    win_a  = (ph_a == '0) && (slot_a != '0) && (slot_a <= SLOT_DATA);
  end

  always_comb begin
    st_d   = st;
    ph_d   = ph_q;
    slot_d = slot_q;
    fs_d   = 1'b0;
    bs_d   = 1'b0;
    bidx_d = bidx;
    if (clr) begin
      st_d   = ST_INIT;
      ph_d   = '0;
      slot_d = '0;
      bidx_d = '0;
    end else begin
      unique case (st)
        ST_INIT: begin
          st_d   = ST_IDLE;
          ph_d   = '0;
          slot_d = '0;
        end
        ST_IDLE: begin
          ph_d   = '0;
          slot_d = '0;
          if (pwr_ok) st_d = ST_ACQ;
        end
        ST_ACQ: begin
          if (!pwr_ok) begin
            st_d = ST_IDLE;
          end else if (vld) begin
            if (hit) begin
              st_d   = ST_RECV;
              ph_d   = '0;
              slot_d = '0;
              fs_d   = 1'b1;
              bidx_d = '0;
            end else if (to_a) begin
              st_d = ST_IDLE;
            end else begin
              ph_d   = ph_a;
              slot_d = slot_a;
            end
          end
        end
        ST_RECV: begin
          if (!pwr_ok) begin
            st_d = ST_IDLE;
          end else if (vld) begin
            if (hit && late_a) begin
              ph_d   = '0;
              slot_d = '0;
              fs_d   = 1'b1;
              bidx_d = '0;
            end else if (to_a) begin
              st_d = ST_IDLE;
            end else begin
              ph_d   = ph_a;
              slot_d = slot_a;
              if (win_a) begin
                bs_d   = 1'b1;
                bidx_d = IDX_W'(slot_a - SLOT_W'(1));
              end
            end
          end
        end
        default: st_d = ST_INIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_INIT;
      ph_q   <= '0;
      slot_q <= '0;
      fs     <= 1'b0;
      bs     <= 1'b0;
      bidx   <= '0;
    end else begin
      st     <= st_d;
      ph_q   <= ph_d;
      slot_q <= slot_d;
      fs     <= fs_d;
      bs     <= bs_d;
      bidx   <= bidx_d;
    end
  end
endmodule

// File: rtl/fsk_rx_sync_ctrl.sv
module fsk_rx_sync_ctrl
  import fsk_sync_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SPB      = 80,
  parameter int BITS     = 17,
  parameter int PWR_WIN  = 80,
  localparam int PWR_W   = 2*SAMPLE_W + $clog2(PWR_WIN),
  localparam int IDX_W   = $clog2(BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [PWR_W-1:0]    pwr_thr,
  input  logic [SAMPLE_W-1:0] imp_thr,
  output logic [1:0]          state,
  output logic                frame_start,
  output logic                bit_strobe,
  output logic [IDX_W-1:0]    bit_idx
);
  logic       rst_n_i;
  logic [PWR_W-1:0] pwr;
  logic       pwr_ok, hit, wipe;
  rx_state_e  st;

  rx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign wipe = clr | (st == ST_INIT);

  rx_power_est #(.W(SAMPLE_W), .WIN(PWR_WIN), .PW(PWR_W)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n_i),
    .wipe  (wipe),
    .vld   (in_valid),
    .smp   (in_sample),
    .pwr   (pwr)
  );

  rx_impulse_det #(.W(SAMPLE_W)) u_imp (
    .smp (in_sample),
    .thr (imp_thr),
    .hit (hit)
  );

  assign pwr_ok = pwr > pwr_thr;

  rx_sync_fsm #(.SPB(SPB), .BITS(BITS), .IDX_W(IDX_W)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .clr    (clr),
    .vld    (in_valid),
    .hit    (hit),
    .pwr_ok (pwr_ok),
    .st     (st),
    .fs     (frame_start),
    .bs     (bit_strobe),
    .bidx   (bit_idx)
  );

  assign state = st;
endmodule

// File: rtl/fsk_rx_sync_ctrl_chk.sv
module fsk_rx_sync_ctrl_chk #(
  parameter int IW = 5,
  parameter int NB = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          in_valid,
  input logic          pwr_ok,
  input logic [1:0]    state,
  input logic          frame_start,
  input logic          bit_strobe,
  input logic [IW-1:0] bit_idx
);
  // R1
  clr_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == 2'd0 && !frame_start && !bit_strobe && bit_idx == '0));
  // R2
  init_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !clr) |=> state == 2'd1);
  // R3
  idle_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && pwr_ok && !clr) |=> state == 2'd2);
  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !pwr_ok && !clr) |=> state == 2'd1);
  // R9
  power_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state[1] && !pwr_ok && !clr) |=> state == 2'd1);
  // R4
  recv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && $past(state) != 2'd3) |-> frame_start);
  // R4
  start_in_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (state == 2'd3 && $past(in_valid)));
  // R5
  strobe_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (state == 2'd3 && !frame_start && bit_idx < IW'(NB)));
  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);
  // R10
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> (!frame_start && !bit_strobe));
endmodule

bind fsk_rx_sync_ctrl fsk_rx_sync_ctrl_chk #(.IW(IDX_W), .NB(BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_i),
  .clr         (clr),
  .in_valid    (in_valid),
  .pwr_ok      (pwr_ok),
  .state       (state),
  .frame_start (frame_start),
  .bit_strobe  (bit_strobe),
  .bit_idx     (bit_idx)
);

// File: tb/fsk_rx_sync_ctrl_test.sv
`timescale 1ns/1ps
module fsk_rx_sync_ctrl_test;
  localparam int SW   = 16;
  localparam int SPB  = 4;
  localparam int NB   = 3;
  localparam int WIN  = 4;
  localparam int PWRW = 2*SW + $clog2(WIN);
  localparam int IW   = $clog2(NB);
  localparam int FRAME = SPB * (NB + 1);
  localparam int TOUT  = SPB * (NB + 2);

  logic clk = 1'b0;
  logic rst_n, clr, in_valid;
  logic [SW-1:0]   in_sample;
  logic [PWRW-1:0] pwr_thr;
  logic [SW-1:0]   imp_thr;
  logic [1:0]      state;
  logic            frame_start, bit_strobe;
  logic [IW-1:0]   bit_idx;

  always #5 clk = ~clk;

  fsk_rx_sync_ctrl #(.SAMPLE_W(SW), .SPB(SPB), .BITS(NB), .PWR_WIN(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_sample(in_sample), .pwr_thr(pwr_thr), .imp_thr(imp_thr),
    .state(state), .frame_start(frame_start), .bit_strobe(bit_strobe),
    .bit_idx(bit_idx)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    strobes_seen = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Reference model built from the requirements
  bit     m_on = 0;
  int     m_st, m_o, m_idx;
  bit     m_fs, m_bs;
  longint m_pwr;
  int     hist [WIN];

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string req, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int s, mag, old;
    bit pok, imp;
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
    if (clr) begin
      m_on = 1; m_st = 0; m_o = 0; m_pwr = 0; m_fs = 0; m_bs = 0; m_idx = 0;
      for (int i = 0; i < WIN; i++) hist[i] = 0;
    end else if (m_on) begin
      s   = int'($signed(in_sample));
      mag = (s < 0) ? -s : s;
      imp = in_valid && (mag > int'(imp_thr));
      pok = m_pwr > longint'(pwr_thr);
      old = m_st;
      m_fs = 0; m_bs = 0;
      case (old)
        0: m_st = 1;
        1: if (pok) begin m_st = 2; m_o = 0; end
        2: if (!pok) m_st = 1;
           else if (in_valid) begin
             if (imp) begin m_st = 3; m_o = 0; m_fs = 1; m_idx = 0; end
             else begin m_o++; if (m_o == TOUT) m_st = 1; end
           end
        default: if (!pok) m_st = 1;
           else if (in_valid) begin
             if (imp && (m_o + 1) >= FRAME) begin m_o = 0; m_fs = 1; m_idx = 0; end
             else if (m_o + 1 == TOUT) m_st = 1;
             else begin
               m_o++;
               if (m_o % SPB == 0 && m_o / SPB >= 1 && m_o / SPB <= NB) begin
                 m_bs = 1; m_idx = m_o / SPB - 1;
               end
             end
           end
      endcase
      if (old == 0) begin
        m_pwr = 0;
        for (int i = 0; i < WIN; i++) hist[i] = 0;
      end else if (in_valid) begin
        m_pwr = m_pwr + longint'(s) * s - longint'(hist[WIN-1]) * hist[WIN-1];
        for (int i = WIN-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
      end
    end
  end

  task automatic compare();
    if (m_on) begin
      chk({cur_req, " state"},       int'(state),       m_st);
      chk({cur_req, " frame_start"}, int'(frame_start), int'(m_fs));
      chk({cur_req, " bit_strobe"},  int'(bit_strobe),  int'(m_bs));
      chk({cur_req, " bit_idx"},     int'(bit_idx),     m_idx);
      if (bit_strobe) strobes_seen++;
    end
  endtask

  task automatic tick(input bit v, input int s);
    @(negedge clk);
    compare();
    clr = 1'b0;
    in_valid = v;
    in_sample = SW'(s);
  endtask

  function automatic int tone(int k);
    return (k % 2 == 0) ? 100 : -100;
  endfunction

  // Offsets 1..len after an impulse; a strong sample at imp_at (0 = none)
  task automatic frame_body(int len, int imp_at, int imp_val);
    for (int o = 1; o <= len; o++)
      tick(1, (o == imp_at) ? imp_val : tone(o));
  endtask

  task automatic go_idle_then_acq();
    repeat (WIN + 2) tick(1, 0);
    repeat (WIN + 2) tick(1, tone(1));
  endtask

  initial begin
    rst_n = 0; clr = 0; in_valid = 0; in_sample = '0;
    pwr_thr = PWRW'(20000); imp_thr = SW'(1000);
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset state", int'(state), 0);
      chk("R1 reset pulses", int'(frame_start | bit_strobe), 0);
      chk("R1 reset bit_idx", int'(bit_idx), 0);
    end
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    @(negedge clk); clr = 1; in_valid = 0;
    tick(1, 0);
    chk("R1 state after clr", int'(state), 0);
    cur_req = "R2";
    tick(1, 0);
    chk("R2 init to idle", int'(state), 1);
    repeat (4) tick(1, 0);

    // R3 equal threshold keeps idle, one below wakes
    cur_req = "R3";
    pwr_thr = PWRW'(40000);
    for (int k = 0; k < 8; k++) tick(1, tone(k));
    chk("R3 equal threshold stays idle", int'(state), 1);
    pwr_thr = PWRW'(39999);
    tick(1, tone(0));
    tick(1, tone(1));
    chk("R3 above threshold acquires", int'(state), 2);
    pwr_thr = PWRW'(20000);

    // R8 acquire timeout with tone but no impulse
    cur_req = "R8";
    for (int k = 0; k < TOUT + 4; k++) tick(1, tone(k));

    // R4 / R5 / R6 / R7 framed reception
    cur_req = "R4";
    tick(1, 2000);
    cur_req = "R5";
    strobes_seen = 0;
    frame_body(FRAME - 1, 0, 0);
    tick(1, tone(0));
    chk("R5 strobes per frame", strobes_seen, NB);
    cur_req = "R7";
    tick(1, -2000);
    cur_req = "R6";
    frame_body(FRAME - 1, 2, -5000);
    cur_req = "R6";
    frame_body(0, 0, 0);
    tick(1, 0);                       // offset FRAME, no impulse
    cur_req = "R7";
    frame_body(TOUT - FRAME - 1, 0, 0);
    tick(1, 1500);                    // impulse at TOUT, accepted
    cur_req = "R6";
    frame_body(FRAME - 1, SPB + 1, 3000);
    cur_req = "R8";
    frame_body(SPB + 2, 0, 0);        // no impulse: timeout to idle

    // R10 gaps inside a frame
    cur_req = "R10";
    go_idle_then_acq();
    tick(1, -32768);
    for (int o = 1; o < FRAME; o++) begin
      tick(0, 5000);
      tick(1, tone(o));
    end
    tick(0, 2000);
    tick(1, 2000);

    // R9 power loss in receive and in acquire
    cur_req = "R9";
    repeat (WIN + 2) tick(1, 0);
    chk("R9 power loss to idle", int'(state), 1);
    repeat (WIN + 2) tick(1, tone(1));
    repeat (WIN + 2) tick(1, 0);
    chk("R9 acquire power loss", int'(state), 1);

    // Sweep of impulse offset across the whole frame and past timeout
    for (int pos = 1; pos <= TOUT + 2; pos++) begin
      cur_req = (pos < FRAME) ? "R6" : ((pos <= TOUT) ? "R7" : "R8");
      go_idle_then_acq();
      tick(1, 2000);
      frame_body(TOUT + 4, pos, (pos % 2 == 0) ? 2500 : -2500);
    end

    repeat (3) tick(1, 0);
    summary();
  end
endmodule